// File: doc/BRIEF.md
# Banked Register File with Minimal Bank Ports

This block is a physical register file with many logical read and write ports, built from several banks that each have one read port and one write port. Every register address is split into a bank select and a row inside that bank. Within one cycle each bank serves at most one row for reading and accepts at most one write. Fixed-priority arbitration decides which requests are served. The issue stage sees a grant or a conflict for every request in the cycle it presents that request. A conflicted request is simply presented again in a later cycle.

Read data is registered inside the bank and arrives one cycle after the grant. Each logical read port then picks its bank's output through a multiplexer. Several read ports that ask for the same register in one cycle share a single bank access, so they are all granted. By default the file holds 80 registers of 64 bits in 8 banks and offers 16 read ports and 8 write ports. These are the ports an eight-wide issue stage needs with two sources per instruction. Every size is a parameter.

Top module: `banked_regfile`

## Requirements
- R1: The bank of a register address is its low log2(BANKS) bits, and the row inside the bank is the remaining upper bits. Requests whose addresses differ in those low bits never conflict with each other.
- R2: A read port granted in cycle t raises `rd_valid` in cycle t+1, and `rd_data` then holds the register contents. A port that is not granted in cycle t shows `rd_valid` low in cycle t+1.
- R3: When valid read requests in one bank name different registers, the lowest-numbered requesting port's register is served. A request for a different register in that bank is not granted.
- R4: Every valid read port whose address equals the served register of its bank is granted in the same cycle and receives the same data.
- R5: For each logical port, `grant` and `conflict` are never both high. A valid request raises exactly one of them, and a port without a valid request raises neither.
- R6: Among valid writes to one bank, including writes to the same register, only the lowest-numbered port is granted. Every other write to that bank is flagged as a conflict and leaves its register unchanged.
- R7: A read and a write to the same register in the same cycle return the value held before the write. The written value is returned to a read in a later cycle.
- R8: While reset is held and after it is released, `rd_valid` is low on every port until a read is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | RD_PORTS | Read request valid per logical port |
| rd_addr | input | RD_PORTS*ADDR_W | Register address per read port, port p at bits [p*ADDR_W +: ADDR_W] |
| rd_grant | output | RD_PORTS | Read served this cycle |
| rd_conflict | output | RD_PORTS | Read lost bank arbitration this cycle |
| rd_valid | output | RD_PORTS | Read data present, one cycle after grant |
| rd_data | output | RD_PORTS*DATA_W | Read data per port, port p at bits [p*DATA_W +: DATA_W] |
| wr_vld | input | WR_PORTS | Write request valid per logical port |
| wr_addr | input | WR_PORTS*ADDR_W | Register address per write port |
| wr_data | input | WR_PORTS*DATA_W | Write data per write port |
| wr_grant | output | WR_PORTS | Write accepted this cycle |
| wr_conflict | output | WR_PORTS | Write lost bank arbitration this cycle |

## Verification
The hardest case to produce is a single cycle in which one bank sees three things together. First, a group of merged reads is served behind a lower-numbered winner. Second, a read for a different row of that bank loses. Third, a write to that same bank races with those reads and names the merged register. Uniform random addresses over 80 registers seldom line up this way. After directed cases for each rule, the random phase therefore draws every address from just two adjacent banks and a few rows. Collisions, merges and read-during-write cases then occur in most cycles, and each one is compared with the bench's reference model.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int NUM_REGS = 80,
  parameter int DATA_W   = 64,
  parameter int RD_PORTS = 16,
  parameter int WR_PORTS = 8,
  parameter int BANKS    = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int BANK_W  = $clog2(BANKS),
  localparam int DEPTH   = (NUM_REGS + BANKS - 1) / BANKS,
  localparam int ROW_W   = ADDR_W - BANK_W,
  localparam int WIDX_W  = (WR_PORTS > 1) ? $clog2(WR_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RD_PORTS-1:0]        rd_vld,
  input  logic [RD_PORTS*ADDR_W-1:0] rd_addr,
  output logic [RD_PORTS-1:0]        rd_grant,
  output logic [RD_PORTS-1:0]        rd_conflict,
  output logic [RD_PORTS-1:0]        rd_valid,
  output logic [RD_PORTS*DATA_W-1:0] rd_data,
  input  logic [WR_PORTS-1:0]        wr_vld,
  input  logic [WR_PORTS*ADDR_W-1:0] wr_addr,
  input  logic [WR_PORTS*DATA_W-1:0] wr_data,
  output logic [WR_PORTS-1:0]        wr_grant,
  output logic [WR_PORTS-1:0]        wr_conflict
);

  logic [ADDR_W-1:0] ra [RD_PORTS];
  logic [ADDR_W-1:0] wa [WR_PORTS];
  logic [DATA_W-1:0] wd [WR_PORTS];

  logic [BANKS-1:0]  rd_busy, wr_busy;
  logic [ADDR_W-1:0] rd_win [BANKS];
  logic [ADDR_W-1:0] wr_win_addr [BANKS];
  logic [DATA_W-1:0] wr_win_data [BANKS];
  logic [WIDX_W-1:0] wr_win_idx [BANKS];

  logic [DATA_W-1:0] mem [BANKS][DEPTH];
  logic [DATA_W-1:0] bank_q [BANKS];
  logic [BANK_W-1:0] sel_q [RD_PORTS];
  logic [RD_PORTS-1:0] valid_q;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign ra[p] = rd_addr[p*ADDR_W +: ADDR_W];
    assign rd_grant[p]    = rd_vld[p] && (rd_win[ra[p][BANK_W-1:0]] == ra[p]);
    assign rd_conflict[p] = rd_vld[p] && !rd_grant[p];
    assign rd_data[p*DATA_W +: DATA_W] = bank_q[sel_q[p]];
  end

  for (genvar p = 0; p < WR_PORTS; p++) begin : g_wr
    assign wa[p] = wr_addr[p*ADDR_W +: ADDR_W];
    assign wd[p] = wr_data[p*DATA_W +: DATA_W];
    assign wr_grant[p]    = wr_vld[p] && (wr_win_idx[wa[p][BANK_W-1:0]] == WIDX_W'(p));
    assign wr_conflict[p] = wr_vld[p] && !wr_grant[p];
  end

  assign rd_valid = valid_q;

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      rd_busy[b]     = 1'b0;
      rd_win[b]      = '0;
      wr_busy[b]     = 1'b0;
      wr_win_addr[b] = '0;
      wr_win_data[b] = '0;
      wr_win_idx[b]  = '0;
    end
    for (int p = 0; p < RD_PORTS; p++) begin
      if (rd_vld[p] && !rd_busy[ra[p][BANK_W-1:0]]) begin
        rd_busy[ra[p][BANK_W-1:0]] = 1'b1;
        rd_win[ra[p][BANK_W-1:0]]  = ra[p];
      end
    end
    for (int p = 0; p < WR_PORTS; p++) begin
      if (wr_vld[p] && !wr_busy[wa[p][BANK_W-1:0]]) begin
        wr_busy[wa[p][BANK_W-1:0]]     = 1'b1;
        wr_win_addr[wa[p][BANK_W-1:0]] = wa[p];
        wr_win_data[wa[p][BANK_W-1:0]] = wd[p];
        wr_win_idx[wa[p][BANK_W-1:0]]  = WIDX_W'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (rd_busy[b])
        bank_q[b] <= mem[b][rd_win[b][ADDR_W-1:BANK_W]];
      if (wr_busy[b])
        mem[b][wr_win_addr[b][ADDR_W-1:BANK_W]] <= wr_win_data[b];
    end
    for (int p = 0; p < RD_PORTS; p++)
      if (rd_grant[p]) sel_q[p] <= ra[p][BANK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= rd_grant;
  end

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int NUM_REGS = 80,
  parameter int DATA_W   = 64,
  parameter int RD_PORTS = 16,
  parameter int WR_PORTS = 8,
  parameter int BANKS    = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int BANK_W  = $clog2(BANKS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [RD_PORTS-1:0]        rd_vld,
  input logic [RD_PORTS*ADDR_W-1:0] rd_addr,
  input logic [RD_PORTS-1:0]        rd_grant,
  input logic [RD_PORTS-1:0]        rd_conflict,
  input logic [RD_PORTS-1:0]        rd_valid,
  input logic [RD_PORTS*DATA_W-1:0] rd_data,
  input logic [WR_PORTS-1:0]        wr_vld,
  input logic [WR_PORTS*ADDR_W-1:0] wr_addr,
  input logic [WR_PORTS*DATA_W-1:0] wr_data,
  input logic [WR_PORTS-1:0]        wr_grant,
  input logic [WR_PORTS-1:0]        wr_conflict
);

  logic [WR_PORTS-1:0] wr_in_bank [BANKS];

  always_comb
    for (int b = 0; b < BANKS; b++)
      for (int p = 0; p < WR_PORTS; p++)
        wr_in_bank[b][p] = wr_grant[p] && (wr_addr[p*ADDR_W +: BANK_W] == BANK_W'(b));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    a_r6_one_write_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_in_bank[b]));
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rp
    a_r5_rd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld[p] |-> (rd_grant[p] ^ rd_conflict[p]));
    a_r5_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld[p] |-> !(rd_grant[p] || rd_conflict[p]));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[p] |=> rd_valid[p]);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_grant[p] |=> !rd_valid[p]);
    if (p > 0) begin : g_merge
      a_r4_merged_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant[0] && rd_grant[p] &&
         rd_addr[0 +: ADDR_W] == rd_addr[p*ADDR_W +: ADDR_W])
        |=> (rd_data[0 +: DATA_W] == rd_data[p*DATA_W +: DATA_W]));
    end
  end

  for (genvar p = 0; p < WR_PORTS; p++) begin : g_wp
    a_r5_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld[p] |-> (wr_grant[p] ^ wr_conflict[p]));
    a_r5_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld[p] |-> !(wr_grant[p] || wr_conflict[p]));
  end

  a_r3_port0_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld[0] |-> rd_grant[0]);
  a_r6_port0_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld[0] |-> wr_grant[0]);

endmodule

bind banked_regfile banked_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RD_PORTS(RD_PORTS),
  .WR_PORTS(WR_PORTS), .BANKS(BANKS)
) u_chk (.*);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int NREG = 80, DW = 64, NR = 16, NW = 8, NB = 8, AW = 7;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [NR-1:0] rd_vld, rd_grant, rd_conflict, rd_valid;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rd_data;
  logic [NW-1:0] wr_vld, wr_grant, wr_conflict;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;

  banked_regfile u_dut (.*);

  int checks = 0, fails = 0;
  logic [DW-1:0] mdl [NREG];
  logic          ev [NR];
  logic [DW-1:0] ed [NR];
  logic          rv [NR];
  int            ra [NR];
  logic          wv [NW];
  int            wa [NW];
  logic [DW-1:0] wd [NW];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear();
    for (int p = 0; p < NR; p++) begin rv[p] = 0; ra[p] = 0; end
    for (int p = 0; p < NW; p++) begin wv[p] = 0; wa[p] = 0; wd[p] = '0; end
  endtask

  task automatic step();
    @(negedge clk);
    for (int p = 0; p < NR; p++) begin
      chk($sformatf("R2 rd_valid port %0d", p), DW'(rd_valid[p]), DW'(ev[p]));
      if (ev[p]) chk($sformatf("R4/R7 rd_data port %0d", p), rd_data[p*DW +: DW], ed[p]);
    end
    for (int p = 0; p < NR; p++) begin rd_vld[p] = rv[p]; rd_addr[p*AW +: AW] = AW'(ra[p]); end
    for (int p = 0; p < NW; p++) begin
      wr_vld[p] = wv[p]; wr_addr[p*AW +: AW] = AW'(wa[p]); wr_data[p*DW +: DW] = wd[p];
    end
    #1;
    for (int p = 0; p < NR; p++) begin
      logic g = 0;
      int first = -1;
      for (int q = 0; q < NR; q++)
        if (first < 0 && rv[q] && (ra[q] % NB) == (ra[p] % NB)) first = q;
      if (rv[p]) g = (ra[first] == ra[p]);
      chk($sformatf("R3 rd_grant port %0d", p), DW'(rd_grant[p]), DW'(g));
      chk($sformatf("R5 rd_conflict port %0d", p), DW'(rd_conflict[p]), DW'(rv[p] && !g));
      ev[p] = g;
      if (g) ed[p] = mdl[ra[p]];
    end
    for (int p = 0; p < NW; p++) begin
      logic g = wv[p];
      for (int q = 0; q < p; q++)
        if (wv[q] && (wa[q] % NB) == (wa[p] % NB)) g = 0;
      chk($sformatf("R6 wr_grant port %0d", p), DW'(wr_grant[p]), DW'(g));
      chk($sformatf("R6 wr_conflict port %0d", p), DW'(wr_conflict[p]), DW'(wv[p] && !g));
      if (g) mdl[wa[p]] = wd[p];
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rd_vld = '0; rd_addr = '0; wr_vld = '0; wr_addr = '0; wr_data = '0;
    for (int p = 0; p < NR; p++) begin ev[p] = 0; ed[p] = '0; end
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    clear();
    repeat (3) @(negedge clk);
    chk("R8 rd_valid in reset", DW'(rd_valid), '0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 rd_valid after reset", DW'(rd_valid), '0);
    chk("R5 idle grants", DW'({rd_grant, wr_grant}), '0);

    // R1: fill all registers, eight writes per cycle into eight banks
    for (int r = 0; r < NREG / NB; r++) begin
      clear();
      for (int p = 0; p < NW; p++) begin
        wv[p] = 1; wa[p] = r * NB + p; wd[p] = {32'hC0DE0000 + 32'(r * NB + p), 32'(~(r * NB + p))};
      end
      step();
    end

    // R1/R3: ports 0-7 distinct banks win, ports 8-15 other rows lose
    clear();
    for (int p = 0; p < NR; p++) begin rv[p] = 1; ra[p] = (p < 8) ? p + 8 : p + 16; end
    step();

    // R4: all sixteen ports on one register
    clear();
    for (int p = 0; p < NR; p++) begin rv[p] = 1; ra[p] = 42; end
    step();

    // R3/R4: higher port loses although lower-numbered merge group exists
    clear();
    rv[3] = 1; ra[3] = 19; rv[5] = 1; ra[5] = 11; rv[9] = 1; ra[9] = 19; rv[12] = 1; ra[12] = 27;
    step();

    // R6/R7: same-register write race and read of the old value
    clear();
    rv[0] = 1; ra[0] = 5;
    wv[2] = 1; wa[2] = 5; wd[2] = 64'h1111_2222_3333_4444;
    wv[6] = 1; wa[6] = 5; wd[6] = 64'hDEAD_BEEF_DEAD_BEEF;
    wv[7] = 1; wa[7] = 13; wd[7] = 64'h7777_7777_7777_7777;
    step();
    clear();
    rv[1] = 1; ra[1] = 5; rv[4] = 1; ra[4] = 13;
    step();
    clear();
    step();

    // Random traffic squeezed into banks 2 and 3
    for (int i = 0; i < 600; i++) begin
      clear();
      for (int p = 0; p < NR; p++) begin
        rv[p] = ($urandom_range(0, 3) != 0);
        ra[p] = $urandom_range(0, 3) * NB + 2 + $urandom_range(0, 1);
      end
      for (int p = 0; p < NW; p++) begin
        wv[p] = ($urandom_range(0, 2) == 0);
        wa[p] = $urandom_range(0, 3) * NB + 2 + $urandom_range(0, 1);
        wd[p] = {$urandom, $urandom};
      end
      step();
    end
    clear();
    step();
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule